// File: doc/BRIEF.md
# Tiled Background Scanline Renderer

The block renders one horizontal line of a tile-based background. It takes 160 pixels from a background built from 8x8 tiles and sends them out as a stream of 24-bit RGB colours. A start pulse captures the horizontal and vertical scroll values, the line number and the control byte. For each tile the line touches, the block reads the tile number from the selected tile map. It then reads the two bit-plane bytes for the tile row and emits the tile's pixels one per clock. Each pixel's 2-bit value passes through a four-entry colour palette.

Tile memory is 8 KiB and is reached through one read port with one clock of latency. The renderer pauses its pixel output while it fetches the map entry and the two pattern bytes of each new tile. A done pulse marks the end of the line. Horizontal fine scroll works by starting part-way into the first tile. Tile numbers can be taken as unsigned or as signed, and the control byte selects which.

Top module: `bg_line_renderer`

## Requirements
- R1: After reset, and until a start pulse, `pix_valid_o`, `done_o` and `mem_req_o` are all low.
- R2: A map entry is read at address 0x1800 + 0x400*ctrl[3] + 32*(((scy+line) >> 3) & 31) + column. The first column is scx >> 3. Each following tile uses the next column, taken modulo 32.
- R3: A tile number t gives a tile index. When ctrl[4] is clear and t < 128, the index is t + 256. Otherwise the index is t. The pattern bytes of a row are at index*16 + 2*row and index*16 + 2*row + 1.
- R4: The row within the tile is (scy + line) & 7, with the sum taken modulo 256. Pixel value bit 0 comes from the byte at the even address and bit 1 from the byte at the odd address. Bit 7 of each byte is the leftmost pixel of the tile.
- R5: The first pixel of the line is at column scx & 7 of the first tile. Later pixels move one column right each time. After column 7 the next map tile begins at column 0.
- R6: A pixel value k comes out as palette entry k. That entry is `pal_i[24*k +: 24]`.
- R7: When ctrl[0] is clear, every pixel comes out as palette entry 0. The memory fetch timing does not change.
- R8: While ctrl[7] is set at start, exactly 160 valid pixels are produced, with `pix_x_o` running 0 to 159 in order. `done_o` is high for one cycle, in the same cycle as pixel 159.
- R9: Memory data returns one cycle after its address. Each tile costs four stall cycles: map read, low byte, high byte and capture. Take the start edge as cycle 0. `done_o` is then seen after edge 4*N + 160, where N is 20 when scx & 7 is 0 and 21 otherwise.
- R10: When ctrl[7] is clear at start, no memory read is made and no pixel is produced. `done_o` rises right after the start edge.
- R11: A start pulse during a line is ignored, and so are changes to the scroll, line and control inputs. The line in progress goes on with the values captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a line; sampled only when idle |
| scx_i | input | 8 | Horizontal scroll |
| scy_i | input | 8 | Vertical scroll |
| line_i | input | 8 | Current line number |
| ctrl_i | input | 8 | Control: bit0 background on, bit3 map select, bit4 unsigned tile data, bit7 display on |
| pal_i | input | 96 | Four 24-bit palette colours, entry k at bits 24k+23:24k |
| mem_req_o | output | 1 | Read strobe for tile memory |
| mem_addr_o | output | 13 | Tile memory byte address |
| mem_rdata_i | input | 8 | Read data, one cycle after the address |
| pix_valid_o | output | 1 | Pixel stream valid |
| pix_rgb_o | output | 24 | Pixel colour |
| pix_x_o | output | 8 | Pixel x index on the line |
| done_o | output | 1 | Line complete pulse |

## Verification
A wrong fine-x or column counter shows up at the port as the wrong colour. A wrong bit order or row select does too. The first wrong pixel shows it at once, in the same cycle as its valid, because each pixel is compared with a model built from the tile formulas. A fault in the stall sequencing moves the done pulse away from cycle 4*N + 160. It can also change the pixel count, and the count is checked when the line ends. Wrong latching or restart handling changes pixels that come after the bad start pulse in the same line.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int COLOR_W  = 24;
  localparam int ADDR_W   = 13;
  localparam int PAL_N    = 4;

  localparam int CTRL_BG_EN    = 0;
  localparam int CTRL_MAP_SEL  = 3;
  localparam int CTRL_DATA_SEL = 4;
  localparam int CTRL_DISP     = 7;

  localparam logic [ADDR_W-1:0] MAP_BASE = 13'h1800;
  localparam logic [ADDR_W-1:0] MAP_ALT  = 13'h0400;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MAP, ST_LO, ST_HI, ST_CAP, ST_PIX, ST_DONE
  } bg_state_e;
endpackage

// File: rtl/bg_addr_gen.sv
module bg_addr_gen
  import bg_pkg::*;
(
  input  logic              map_sel_i,
  input  logic              data_sel_i,
  input  logic [4:0]        map_row_i,
  input  logic [4:0]        map_col_i,
  input  logic [2:0]        tile_row_i,
  input  logic [7:0]        tile_num_i,
  output logic [ADDR_W-1:0] map_addr_o,
  output logic [ADDR_W-2:0] row_base_o
);
  logic [8:0] tile_idx;

  always_comb begin
    map_addr_o = MAP_BASE | (map_sel_i ? MAP_ALT : '0) | {3'b0, map_row_i, map_col_i};
    // signed mode: numbers 0..127 live above 0..255 block
    tile_idx   = (!data_sel_i && !tile_num_i[7]) ? {1'b1, tile_num_i} : {1'b0, tile_num_i};
    row_base_o = {tile_idx, tile_row_i};
  end
endmodule

// File: rtl/bg_pixel_unit.sv
module bg_pixel_unit
  import bg_pkg::*;
#(
  parameter int X_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_lo_i,
  input  logic                     load_hi_i,
  input  logic [7:0]               data_i,
  input  logic                     emit_i,
  input  logic [2:0]               fine_i,
  input  logic [X_W-1:0]           x_i,
  input  logic                     bg_en_i,
  input  logic [PAL_N*COLOR_W-1:0] pal_i,
  output logic                     valid_o,
  output logic [COLOR_W-1:0]       rgb_o,
  output logic [X_W-1:0]           x_o
);
  logic [7:0] lo_q, hi_q;
  logic [1:0] pix_val;
  logic [2:0] bit_sel;

  always_comb begin
    bit_sel = 3'd7 - fine_i;
    pix_val = bg_en_i ? {hi_q[bit_sel], lo_q[bit_sel]} : 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      valid_o <= 1'b0;
      rgb_o   <= '0;
      x_o     <= '0;
    end else begin
      if (load_lo_i) lo_q <= data_i;
      if (load_hi_i) hi_q <= data_i;
      valid_o <= emit_i;
      if (emit_i) begin
        rgb_o <= pal_i[pix_val*COLOR_W +: COLOR_W];
        x_o   <= x_i;
      end
    end
  end

  p_x_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) |-> x_o == $past(x_o) + 1'b1);
endmodule

// File: rtl/bg_line_renderer.sv
module bg_line_renderer
  import bg_pkg::*;
#(
  parameter int LINE_W = 160,
  localparam int X_W   = $clog2(LINE_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [7:0]               scx_i,
  input  logic [7:0]               scy_i,
  input  logic [7:0]               line_i,
  input  logic [7:0]               ctrl_i,
  input  logic [PAL_N*COLOR_W-1:0] pal_i,
  output logic                     mem_req_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic [7:0]               mem_rdata_i,
  output logic                     pix_valid_o,
  output logic [COLOR_W-1:0]       pix_rgb_o,
  output logic [X_W-1:0]           pix_x_o,
  output logic                     done_o
);
  bg_state_e state_q, state_d;
  logic [7:0]      ctrl_q;
  logic [7:0]      ypos_q;
  logic [4:0]      col_q;
  logic [2:0]      fx_q;
  logic [X_W-1:0]  cnt_q;
  logic [ADDR_W-2:0] base_q;
  logic [ADDR_W-1:0] map_addr;
  logic [ADDR_W-2:0] row_base;
  logic            emit;
  logic [7:0]      ypos_in;

  assign ypos_in = scy_i + line_i;
  assign emit    = (state_q == ST_PIX);
  assign done_o  = (state_q == ST_DONE);

  bg_addr_gen u_addr (
    .map_sel_i  (ctrl_q[CTRL_MAP_SEL]),
    .data_sel_i (ctrl_q[CTRL_DATA_SEL]),
    .map_row_i  (ypos_q[7:3]),
    .map_col_i  (col_q),
    .tile_row_i (ypos_q[2:0]),
    .tile_num_i (mem_rdata_i),
    .map_addr_o (map_addr),
    .row_base_o (row_base)
  );

  bg_pixel_unit #(.X_W(X_W)) u_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_lo_i (state_q == ST_HI),
    .load_hi_i (state_q == ST_CAP),
    .data_i    (mem_rdata_i),
    .emit_i    (emit),
    .fine_i    (fx_q),
    .x_i       (cnt_q),
    .bg_en_i   (ctrl_q[CTRL_BG_EN]),
    .pal_i     (pal_i),
    .valid_o   (pix_valid_o),
    .rgb_o     (pix_rgb_o),
    .x_o       (pix_x_o)
  );

  always_comb begin
    mem_req_o  = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      ST_MAP: begin mem_req_o = 1'b1; mem_addr_o = map_addr; end
      ST_LO:  begin mem_req_o = 1'b1; mem_addr_o = {row_base, 1'b0}; end
      ST_HI:  begin mem_req_o = 1'b1; mem_addr_o = {base_q, 1'b1}; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ctrl_i[CTRL_DISP] ? ST_MAP : ST_DONE;
      ST_MAP:  state_d = ST_LO;
      ST_LO:   state_d = ST_HI;
      ST_HI:   state_d = ST_CAP;
      ST_CAP:  state_d = ST_PIX;
      ST_PIX: begin
        if (cnt_q == X_W'(LINE_W - 1)) state_d = ST_DONE;
        else if (fx_q == 3'd7)          state_d = ST_MAP;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      ypos_q  <= '0;
      col_q   <= '0;
      fx_q    <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        ctrl_q <= ctrl_i;
        ypos_q <= ypos_in;
        col_q  <= scx_i[7:3];
        fx_q   <= scx_i[2:0];
        cnt_q  <= '0;
      end
      if (state_q == ST_LO) base_q <= row_base;
      if (emit) begin
        cnt_q <= cnt_q + 1'b1;
        fx_q  <= fx_q + 1'b1;
        if (fx_q == 3'd7) col_q <= col_q + 1'b1;
      end
    end
  end

  p_done_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && ctrl_q[CTRL_DISP] |-> pix_valid_o && pix_x_o == X_W'(LINE_W - 1));
  p_off_no_pix_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ctrl_q[CTRL_DISP] |-> !pix_valid_o);
  p_fetch_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MAP && $past(state_q == ST_PIX) |-> fx_q == 3'd0);
  p_no_pix_in_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q == ST_MAP) |-> !pix_valid_o || $past(state_q, 2) == ST_PIX);
endmodule

// File: tb/tb_bg_line_renderer.sv
`timescale 1ns/1ps
module tb_bg_line_renderer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  scx_i = '0, scy_i = '0, line_i = '0, ctrl_i = '0;
  logic [95:0] pal_i;
  logic        mem_req_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_rdata_i;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;
  logic [7:0]  pix_x_o;
  logic        done_o;

  int vectors = 0;
  int errors  = 0;
  int seed    = 7;
  logic [23:0] pal_e [4];

  always #2 clk_i = ~clk_i;

  bg_line_renderer dut (
    .clk_i, .rst_ni, .start_i, .scx_i, .scy_i, .line_i, .ctrl_i, .pal_i,
    .mem_req_o, .mem_addr_o, .mem_rdata_i,
    .pix_valid_o, .pix_rgb_o, .pix_x_o, .done_o
  );

  function automatic logic [7:0] memf(int a);
    return 8'((a * 73 + (a >> 4) * 29 + seed) ^ (a >> 7));
  endfunction

  // registered memory: one cycle latency
  always @(posedge clk_i) mem_rdata_i <= memf(int'(mem_addr_o));

  function automatic logic [23:0] ref_pix(int sx, int sy, int ln, int ct, int p);
    int abs_x, col, fine, y, row, mrow, tn, idx, lo, hi, v;
    abs_x = sx + p;
    col   = (abs_x >> 3) % 32;
    fine  = abs_x % 8;
    y     = (sy + ln) % 256;
    row   = y % 8;
    mrow  = (y / 8) % 32;
    tn    = int'(memf(6144 + ((ct >> 3) & 1) * 1024 + mrow * 32 + col));  // R2
    idx   = (((ct >> 4) & 1) == 0 && tn < 128) ? tn + 256 : tn;           // R3
    lo    = int'(memf(idx * 16 + row * 2));                               // R4
    hi    = int'(memf(idx * 16 + row * 2 + 1));
    v     = ((hi >> (7 - fine)) & 1) * 2 + ((lo >> (7 - fine)) & 1);      // R5
    if ((ct & 1) == 0) v = 0;                                             // R7
    return pal_e[v];                                                      // R6
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_line(int sx, int sy, int ln, int ct, bit restart, string tag);
    logic [23:0] exp_rgb [160];
    int k, got, reads, exp_k, nt;
    bit disp, fin;
    disp = ((ct >> 7) & 1) == 1;
    for (int p = 0; p < 160; p++) exp_rgb[p] = ref_pix(sx, sy, ln, ct, p);
    nt    = ((sx & 7) == 0) ? 20 : 21;
    exp_k = disp ? 4 * nt + 160 : 0;
    @(negedge clk_i);
    scx_i = 8'(sx); scy_i = 8'(sy); line_i = 8'(ln); ctrl_i = 8'(ct);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0; got = 0; reads = 0; fin = 0;
    while (!fin) begin
      if (mem_req_o) reads++;
      if (pix_valid_o) begin
        if (got < 160) begin
          check(pix_rgb_o == exp_rgb[got], tag, $sformatf("rgb px%0d", got), pix_rgb_o, exp_rgb[got]);
          check(pix_x_o == 8'(got), "R8", "x index", pix_x_o, got);
        end
        got++;
      end
      if (done_o) begin
        fin = 1;
        check(got == (disp ? 160 : 0), "R8", "pixel count", got, disp ? 160 : 0);
        check(k == exp_k, "R9", "done cycle", k, exp_k);
        if (!disp) check(reads == 0, "R10", "reads while off", reads, 0);
      end else begin
        if (restart && k == 40) begin  // R11: restart attempt mid-line
          start_i = 1'b1; scx_i = ~scx_i; ctrl_i = 8'h11; line_i = line_i + 8'd3;
        end else if (restart && k == 41) start_i = 1'b0;
        if (k > 3000) begin
          fin = 1;
          check(0, tag, "line hung", k, exp_k);
        end
        @(negedge clk_i);
        k++;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    pal_e[0] = 24'h102030; pal_e[1] = 24'hA0B0C0;
    pal_e[2] = 24'h55AA11; pal_e[3] = 24'hFFEE01;
    pal_i = {pal_e[3], pal_e[2], pal_e[1], pal_e[0]};
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(!pix_valid_o, "R1", "valid in reset", pix_valid_o, 0);
    check(!done_o, "R1", "done in reset", done_o, 0);
    check(!mem_req_o, "R1", "req in reset", mem_req_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!pix_valid_o && !done_o && !mem_req_o, "R1", "idle after reset", {pix_valid_o, done_o, mem_req_o}, 0);

    run_line(0, 0, 0, 8'h91, 0, "R2_R4_R6");       // unsigned data, map 0
    run_line(13, 250, 10, 8'h89, 0, "R3_R5");      // signed data, map 1, fine scroll
    seed = 201;
    run_line(255, 7, 143, 8'h81, 0, "R2_R5");      // column wrap, fine 7
    run_line(100, 33, 77, 8'h99, 0, "R2_R3_R4");   // unsigned, map 1
    run_line(5, 12, 3, 8'h90, 0, "R7");            // background off
    run_line(21, 0, 0, 8'h11, 0, "R10");           // display off
    seed = 57;
    run_line(42, 90, 60, 8'h81, 1, "R11");         // ignored restart
    run_line(8, 1, 2, 8'h91, 0, "R9");             // aligned scroll timing
    repeat (3) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule